// File: doc/BRIEF.md
# Aging-Counter Replacement Victim Picker

This block picks which of a fixed set of main-memory frames should be given up when a new page has to come in. Each frame has a small age counter. A periodic tick makes every occupied frame one step older. An access to a frame makes it young again. When asked, the block names one frame: an unoccupied frame if one exists, and otherwise the oldest occupied frame. It also says whether that frame holds modified data, which must be copied back to disk before the frame is reused.

The surrounding memory manager drives the block with four kinds of event. An install marks a frame as occupied by a freshly loaded page. A reference reports a read or write access to a frame. A tick is the aging interval. A select asks for a victim. The victim is reported one cycle after the select. Moving pages and updating the page table are left to other logic.

Top module: `lru_frame_picker`

## Requirements
- R1: After a synchronous reset every frame is unoccupied and `victim_valid_o` is low. The first select then names frame 0 as a free frame.
- R2: On a cycle with `tick_i` high, the age of every occupied frame that is not referenced or installed in that cycle rises by one. An age already at its maximum (255 with the default 8-bit width) stays at the maximum and does not wrap to zero.
- R3: A reference to an occupied frame sets that frame's age to zero. When `ref_write_i` is high, the reference also marks the frame as modified.
- R4: A reference and a tick in the same cycle leave the referenced frame at age zero.
- R5: A reference to an unoccupied frame changes nothing. The frame stays free and does not become modified.
- R6: When any frame is unoccupied, the victim is the lowest-numbered unoccupied frame, reported with `victim_free_o` = 1 and `victim_dirty_o` = 0.
- R7: When every frame is occupied, the victim is the frame with the greatest age. Among frames that share the greatest age, the lowest-numbered one is chosen. `victim_free_o` is then 0.
- R8: For an occupied victim, `victim_dirty_o` is 1 exactly when a write reference has reached that frame since it was last installed.
- R9: `victim_valid_o` is high in exactly the cycle after a cycle with `select_i` high. The reported victim reflects the frame state as it stood before the updates of the select cycle.
- R10: An install makes the named frame occupied, with age zero and the modified mark cleared. An install takes precedence over a reference or tick to the same frame in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Aging interval strobe |
| ref_valid_i | input | 1 | A frame was accessed this cycle |
| ref_write_i | input | 1 | The access was a write |
| ref_frame_i | input | IDX_W (5) | Frame that was accessed |
| install_i | input | 1 | A page was loaded into a frame this cycle |
| install_frame_i | input | IDX_W (5) | Frame that received the page |
| select_i | input | 1 | Request for a victim |
| victim_valid_o | output | 1 | Victim fields are valid this cycle |
| victim_frame_o | output | IDX_W (5) | Chosen frame |
| victim_free_o | output | 1 | Chosen frame is unoccupied |
| victim_dirty_o | output | 1 | Chosen frame must be written back first |

## Verification
The bench drives the ages up to the ceiling and then past it. A wrapping counter would send a saturated frame back to age zero, so the oldest frame would not be the one picked. The bench lines up exact ties to check that the lowest index wins; a design that used a non-strict compare would return the highest tied index instead. A reference is issued in the same cycle as a tick, and an install in the same cycle as a write reference. A wrong priority in either case would pick a different victim or report a stale dirty mark. Accesses to unoccupied frames are also sent. A design that honoured them would stop offering that frame as free.

// File: rtl/lru_pick_pkg.sv
package lru_pick_pkg;
  localparam int unsigned FRAMES_DFLT = 32;
  localparam int unsigned AGE_W_DFLT  = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_age_bank.sv
module lru_age_bank #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic           ref_valid_i,
  input  logic           ref_write_i,
  input  logic [IW-1:0]  ref_idx_i,
  input  logic           inst_valid_i,
  input  logic [IW-1:0]  inst_idx_i,
  output logic [N*W-1:0] age_o,
  output logic [N-1:0]   res_o,
  output logic [N-1:0]   dirty_o
);
  localparam logic [W-1:0] AGE_MAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_frame
    logic [W-1:0] age_q;
    logic         res_q;
    logic         dirty_q;
    logic         hit_ref;
    logic         hit_inst;

    assign hit_ref  = ref_valid_i  && (ref_idx_i  == IW'(g));
    assign hit_inst = inst_valid_i && (inst_idx_i == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q   <= '0;
        res_q   <= 1'b0;
        dirty_q <= 1'b0;
      end else if (hit_inst) begin
        age_q   <= '0;
        res_q   <= 1'b1;
        dirty_q <= 1'b0;
      end else if (res_q) begin
        if (hit_ref) begin
          age_q <= '0;
          if (ref_write_i) dirty_q <= 1'b1;
        end else if (tick_i && (age_q != AGE_MAX)) begin
          age_q <= age_q + 1'b1;
        end
      end
    end

    assign age_o[g*W +: W] = age_q;
    assign res_o[g]        = res_q;
    assign dirty_o[g]      = dirty_q;
  end
endmodule

// File: rtl/lru_victim_find.sv
module lru_victim_find #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 5
) (
  input  logic [N*W-1:0] age_i,
  input  logic [N-1:0]   res_i,
  input  logic [N-1:0]   dirty_i,
  output logic [IW-1:0]  idx_o,
  output logic           free_o,
  output logic           dirty_o
);
  logic          free_found;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] best_idx;
  logic [W-1:0]  best_age;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    best_idx   = '0;
    best_age   = age_i[W-1:0];
    for (int i = 0; i < N; i++) begin
      if (!res_i[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
      // strict compare keeps the lowest index on ties
      if (age_i[i*W +: W] > best_age) begin
        best_age = age_i[i*W +: W];
        best_idx = IW'(i);
      end
    end
  end

  assign idx_o   = free_found ? free_idx : best_idx;
  assign free_o  = free_found;
  assign dirty_o = free_found ? 1'b0 : dirty_i[best_idx];
endmodule

// File: rtl/lru_frame_picker.sv
module lru_frame_picker
  import lru_pick_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = FRAMES_DFLT,
  parameter int unsigned AGE_W      = AGE_W_DFLT,
  localparam int unsigned IDX_W     = idx_width(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ref_valid_i,
  input  logic             ref_write_i,
  input  logic [IDX_W-1:0] ref_frame_i,
  input  logic             install_i,
  input  logic [IDX_W-1:0] install_frame_i,
  input  logic             select_i,
  output logic             victim_valid_o,
  output logic [IDX_W-1:0] victim_frame_o,
  output logic             victim_free_o,
  output logic             victim_dirty_o
);
  logic [NUM_FRAMES*AGE_W-1:0] age_flat;
  logic [NUM_FRAMES-1:0]       res_vec;
  logic [NUM_FRAMES-1:0]       dirty_vec;
  logic [IDX_W-1:0]            pick_idx;
  logic                        pick_free;
  logic                        pick_dirty;

  lru_age_bank #(.N(NUM_FRAMES), .W(AGE_W), .IW(IDX_W)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .ref_valid_i  (ref_valid_i),
    .ref_write_i  (ref_write_i),
    .ref_idx_i    (ref_frame_i),
    .inst_valid_i (install_i),
    .inst_idx_i   (install_frame_i),
    .age_o        (age_flat),
    .res_o        (res_vec),
    .dirty_o      (dirty_vec)
  );

  lru_victim_find #(.N(NUM_FRAMES), .W(AGE_W), .IW(IDX_W)) u_find (
    .age_i   (age_flat),
    .res_i   (res_vec),
    .dirty_i (dirty_vec),
    .idx_o   (pick_idx),
    .free_o  (pick_free),
    .dirty_o (pick_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid_o <= 1'b0;
      victim_frame_o <= '0;
      victim_free_o  <= 1'b0;
      victim_dirty_o <= 1'b0;
    end else begin
      victim_valid_o <= select_i;
      if (select_i) begin
        victim_frame_o <= pick_idx;
        victim_free_o  <= pick_free;
        victim_dirty_o <= pick_dirty;
      end
    end
  end
endmodule

// File: rtl/lru_frame_picker_chk.sv
module lru_frame_picker_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           tick_i,
  input logic           ref_valid_i,
  input logic [IW-1:0]  ref_idx_i,
  input logic           inst_valid_i,
  input logic [IW-1:0]  inst_idx_i,
  input logic           select_i,
  input logic           victim_valid_o,
  input logic           victim_free_o,
  input logic           victim_dirty_o,
  input logic [N*W-1:0] age_i,
  input logic [N-1:0]   res_i
);
  localparam logic [W-1:0] AGE_MAX = '1;

  // R9
  select_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    select_i |=> victim_valid_o);
  // R9
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !select_i |=> !victim_valid_o);
  // R6
  free_not_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (victim_valid_o && victim_free_o) |-> !victim_dirty_o);

  for (genvar g = 0; g < N; g++) begin : g_chk
    logic hit_ref;
    logic hit_inst;
    assign hit_ref  = ref_valid_i  && (ref_idx_i  == IW'(g));
    assign hit_inst = inst_valid_i && (inst_idx_i == IW'(g));

    // R3
    ref_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (res_i[g] && hit_ref) |=> (age_i[g*W +: W] == '0));
    // R2
    age_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (res_i[g] && !hit_ref && !hit_inst && age_i[g*W +: W] == AGE_MAX)
      |=> (age_i[g*W +: W] == AGE_MAX));
    // R2
    age_step_chk: assert property (@(posedge clk) disable iff (rst)
      (res_i[g] && tick_i && !hit_ref && !hit_inst && age_i[g*W +: W] != AGE_MAX)
      |=> (age_i[g*W +: W] == $past(age_i[g*W +: W]) + 1'b1));
    // R5
    res_only_by_install_chk: assert property (@(posedge clk) disable iff (rst)
      (!res_i[g] && !hit_inst) |=> !res_i[g]);
  end
endmodule

bind lru_frame_picker lru_frame_picker_chk #(
  .N(NUM_FRAMES), .W(AGE_W), .IW(IDX_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick_i         (tick_i),
  .ref_valid_i    (ref_valid_i),
  .ref_idx_i      (ref_frame_i),
  .inst_valid_i   (install_i),
  .inst_idx_i     (install_frame_i),
  .select_i       (select_i),
  .victim_valid_o (victim_valid_o),
  .victim_free_o  (victim_free_o),
  .victim_dirty_o (victim_dirty_o),
  .age_i          (age_flat),
  .res_i          (res_vec)
);

// File: tb/test_lru_frame_picker.sv
module test_lru_frame_picker;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 32;
  localparam int IW  = 5;
  localparam int MAXA = 255;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick_i, ref_valid_i, ref_write_i, install_i, select_i;
  logic [IW-1:0] ref_frame_i, install_frame_i;
  logic          victim_valid_o, victim_free_o, victim_dirty_o;
  logic [IW-1:0] victim_frame_o;

  int checks = 0;
  int errors = 0;

  int m_age   [N];
  bit m_res   [N];
  bit m_dirty [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_frame_picker i_lru_frame_picker (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ref_valid_i(ref_valid_i),
    .ref_write_i(ref_write_i), .ref_frame_i(ref_frame_i), .install_i(install_i),
    .install_frame_i(install_frame_i), .select_i(select_i),
    .victim_valid_o(victim_valid_o), .victim_frame_o(victim_frame_o),
    .victim_free_o(victim_free_o), .victim_dirty_o(victim_dirty_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_pick(output int idx, output bit fr, output bit dt);
    int best = 0;
    idx = -1; fr = 0; dt = 0;
    for (int f = 0; f < N; f++)
      if (!m_res[f] && idx < 0) begin idx = f; fr = 1; end
    if (idx < 0) begin
      for (int f = 1; f < N; f++) if (m_age[f] > m_age[best]) best = f;
      idx = best; dt = m_dirty[best];
    end
  endtask

  // one clock cycle of stimulus, model update and result check
  task automatic cyc(input bit tk, input bit rv, input bit rw, input int ri,
                     input bit iv, input int ii, input bit sel, input string req);
    int ei; bit ef; bit ed;
    @(negedge clk);
    tick_i = tk; ref_valid_i = rv; ref_write_i = rw; ref_frame_i = IW'(ri);
    install_i = iv; install_frame_i = IW'(ii); select_i = sel;
    model_pick(ei, ef, ed);
    @(posedge clk);
    for (int f = 0; f < N; f++) begin
      if (iv && ii == f) begin m_res[f] = 1; m_age[f] = 0; m_dirty[f] = 0; end
      else if (m_res[f]) begin
        if (rv && ri == f) begin m_age[f] = 0; if (rw) m_dirty[f] = 1; end
        else if (tk && m_age[f] < MAXA) m_age[f]++;
      end
    end
    #1;
    check(victim_valid_o == sel, "R9 valid", int'(victim_valid_o), int'(sel));
    if (sel) begin
      check(int'(victim_frame_o) == ei, {req, " frame"}, int'(victim_frame_o), ei);
      check(victim_free_o == ef, {req, " free"}, int'(victim_free_o), int'(ef));
      check(victim_dirty_o == ed, {req, " dirty"}, int'(victim_dirty_o), int'(ed));
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 0, 0, 0, "tick");
  endtask
  task automatic ref_all_but(input int skip);
    for (int f = 0; f < N; f++) if (f != skip) cyc(0, 1, 0, f, 0, 0, 0, "ref");
  endtask
  task automatic sel(input string req);
    cyc(0, 0, 0, 0, 0, 0, 1, req);
  endtask

  task automatic t_reset;
    rst = 1; tick_i = 0; ref_valid_i = 0; ref_write_i = 0; ref_frame_i = '0;
    install_i = 0; install_frame_i = '0; select_i = 0;
    for (int f = 0; f < N; f++) begin m_age[f] = 0; m_res[f] = 0; m_dirty[f] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    check(victim_valid_o == 0, "R1 valid low after reset", int'(victim_valid_o), 0);
    sel("R1 first pick");
  endtask

  task automatic t_nonres_ignored;
    cyc(0, 1, 1, 0, 0, 0, 0, "R5 stim");
    sel("R5 free frame untouched");
  endtask

  task automatic t_free_pick;
    for (int f = 0; f < 4; f++) cyc(0, 0, 0, 0, 1, f, 0, "R10 install");
    sel("R6 lowest free");
    cyc(0, 0, 0, 0, 1, 7, 0, "R10 install");
    for (int f = 4; f < 7; f++) cyc(1, 0, 0, 0, 1, f, 0, "R10 install");
    sel("R6 skip occupied");
    for (int f = 0; f < N; f++) cyc(0, 0, 0, 0, 1, f, 0, "R10 install");
    sel("R7 all zero tie");
  endtask

  task automatic t_tie;
    ticks(3);
    sel("R7 equal ages pick lowest");
    cyc(0, 1, 0, 0, 0, 0, 0, "R3 ref");
    sel("R3 referenced frame young");
    idle(1);
  endtask

  task automatic t_same_cycle;
    ref_all_but(-1);
    cyc(1, 1, 0, 0, 0, 0, 0, "R4 stim");
    sel("R4 ref beats tick");
    // select in same cycle as a reference to the current victim
    cyc(0, 1, 0, 1, 0, 0, 1, "R9 pre-update state");
    sel("R9 after ref");
  endtask

  task automatic t_dirty;
    cyc(0, 1, 1, 5, 0, 0, 0, "R3 write");
    ticks(2);
    ref_all_but(5);
    sel("R8 dirty victim");
    cyc(0, 1, 1, 5, 1, 5, 0, "R10 install with write");
    ticks(1);
    ref_all_but(5);
    sel("R10 install clears dirty");
  endtask

  task automatic t_saturate;
    ref_all_but(-1);
    ticks(5);
    ref_all_but(31);
    ticks(2);
    sel("R2 oldest after steps");
    ref_all_but(-1);
    ticks(256);
    cyc(0, 1, 0, 0, 0, 0, 0, "R2 ref");
    ticks(1);
    sel("R2 saturated not wrapped");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_nonres_ignored();
    t_free_pick();
    t_tie();
    t_same_cycle();
    t_dirty();
    t_saturate();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule